// File: doc/BRIEF.md
# Four-Channel Edge Capture Unit

This block records time stamps for external events. A 16-bit free-running count arrives on an input. Each of four channel pins goes through a two-flop synchroniser. When a channel sees its chosen transition, it copies the count into that channel's capture register and raises that channel's pending flag. Each channel chooses its transition with a 2-bit selector. A per-channel enable decides whether a pending flag drives that channel's interrupt output.

Software uses a small register bus with an address, a write strobe, a read strobe, byte-wide write data and a read-modify-write qualifier. Addresses 0 to 3 return the four capture registers as full 16-bit words; those registers cannot be written. Address 4 holds the control byte for channels 0 and 1, and address 5 holds the control byte for channels 2 and 3. Each control byte serves one even channel and one odd channel. A pending flag is cleared only by writing 0 to it. During a read-modify-write access the flag bits read back as 1, so rewriting a neighbouring field cannot clear a flag by accident.

Top module: `edge_capture_quad`

## Requirements
- R1: When a pin change is sampled at clock edge k, the capture register holds the counter value that was present during the cycle ending at edge k+2. That value is loaded at edge k+2.
- R2: The edge selector encodings are 00 = no capture, 01 = rising, 10 = falling and 11 = both edges. A transition that does not match the selector leaves both the capture register and the flag unchanged.
- R3: A bus write to addresses 0 to 3 has no effect. A read of address n returns capture register n on bus_rdata[15:0].
- R4: The control byte for channel pair (2g, 2g+1) is at address 4+g and reads back on bus_rdata[7:0], with the upper bits 0. Its bits are: 7 = odd flag, 6 = even flag, 5 = odd enable, 4 = even enable, 3:2 = odd selector, 1:0 = even selector.
- R5: A channel's pending flag becomes 1 at the same clock edge that loads its capture register.
- R6: Writing 0 to a flag bit clears that flag. Writing 1 to a flag bit leaves the flag as it was.
- R7: If an edge and a clearing write hit the same flag in the same cycle, the flag ends at 1.
- R8: A read with bus_rmw high returns 1 in bits 7 and 6 of a control byte. The flags themselves do not change.
- R9: irq_o[n] is high exactly while channel n's flag and enable are both 1.
- R10: After synchronous reset, all flags, enables, selectors, capture registers, bus_rdata and irq_o are 0.
- R11: bus_rdata is registered. It carries the read data in the cycle after bus_rd and holds its value whenever bus_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_i | input | 16 | Free-running count to be captured |
| pin_i | input | 4 | Asynchronous channel event inputs |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rmw | input | 1 | Read belongs to a read-modify-write access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 16 | Registered read data |
| irq_o | output | 4 | Per-channel interrupt levels |

## Verification
The assertions check the following on every cycle:
- A detected edge loads the previous cycle's count and sets the flag.
- A capture register does not change without a detected edge.
- Writing 1 to a flag never clears it.
- Writing 0 to a flag clears it unless an edge arrives in the same cycle.
- Read data holds while no read is issued.

Only the bench scenarios can show the following:
- The two-cycle synchroniser latency against a known count.
- Each selector encoding, including the disabled channel.
- The byte layout seen over the bus.
- The read-modify-write view of the flags.
- A hardware set and a software clear landing on the same edge.

// File: rtl/ecq_pkg.sv
package ecq_pkg;
  typedef enum logic [1:0] {
    ES_OFF  = 2'b00,
    ES_RISE = 2'b01,
    ES_FALL = 2'b10,
    ES_BOTH = 2'b11
  } edge_sel_e;

  localparam int CTL_FLAG_LO = 6;
  localparam int CTL_EN_LO   = 4;
  localparam int CTL_SEL_LO  = 0;
endpackage

// File: rtl/ecq_sync_edge.sv
module ecq_sync_edge #(
  parameter int NUM_CH = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_CH-1:0]      pin,
  input  logic [NUM_CH-1:0][1:0] sel,
  output logic [NUM_CH-1:0]      hit
);
  import ecq_pkg::*;

  logic [NUM_CH-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= pin;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_comb begin
      case (edge_sel_e'(sel[c]))
        ES_RISE: hit[c] = s2_q[c] & ~s3_q[c];
        ES_FALL: hit[c] = ~s2_q[c] & s3_q[c];
        ES_BOTH: hit[c] = s2_q[c] ^ s3_q[c];
        default: hit[c] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/ecq_capture_bank.sv
module ecq_capture_bank #(
  parameter int NUM_CH = 4,
  parameter int TW     = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_CH-1:0]       hit,
  input  logic [TW-1:0]           cnt,
  output logic [NUM_CH-1:0][TW-1:0] cap
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_cap
    always_ff @(posedge clk) begin
      if (rst)         cap[c] <= '0;
      else if (hit[c]) cap[c] <= cnt;
    end
  end
endmodule

// File: rtl/ecq_ctrl.sv
module ecq_ctrl #(
  parameter int NUM_CH  = 4,
  localparam int NUM_GRP = NUM_CH / 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_GRP-1:0]      wr_grp,
  input  logic [7:0]              wdata,
  input  logic [NUM_CH-1:0]       hit,
  output logic [NUM_CH-1:0]       flag,
  output logic [NUM_CH-1:0]       ien,
  output logic [NUM_CH-1:0][1:0]  sel,
  output logic [NUM_GRP-1:0][7:0] ctl_byte
);
  import ecq_pkg::*;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    for (genvar h = 0; h < 2; h++) begin : g_half
      localparam int CH = 2 * g + h;

      always_ff @(posedge clk) begin
        if (rst) begin
          flag[CH] <= 1'b0;
          ien[CH]  <= 1'b0;
          sel[CH]  <= ES_OFF;
        end else begin
          if (hit[CH])        flag[CH] <= 1'b1;
          else if (wr_grp[g]) flag[CH] <= flag[CH] & wdata[CTL_FLAG_LO + h];
          if (wr_grp[g]) begin
            ien[CH] <= wdata[CTL_EN_LO + h];
            sel[CH] <= wdata[CTL_SEL_LO + 2*h +: 2];
          end
        end
      end
    end

    assign ctl_byte[g] = {flag[2*g+1], flag[2*g], ien[2*g+1], ien[2*g],
                          sel[2*g+1], sel[2*g]};
  end
endmodule

// File: rtl/edge_capture_quad.sv
module edge_capture_quad #(
  parameter int  NUM_CH  = 4,
  parameter int  TW      = 16,
  localparam int NUM_GRP = NUM_CH / 2,
  localparam int AW      = $clog2(NUM_CH + NUM_GRP)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TW-1:0]     cnt_i,
  input  logic [NUM_CH-1:0] pin_i,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_rmw,
  input  logic [7:0]        bus_wdata,
  output logic [TW-1:0]     bus_rdata,
  output logic [NUM_CH-1:0] irq_o
);
  logic [NUM_CH-1:0]         edge_hit;
  logic [NUM_CH-1:0]         flag_q;
  logic [NUM_CH-1:0]         ien_q;
  logic [NUM_CH-1:0][1:0]    sel_q;
  logic [NUM_CH-1:0][TW-1:0] cap_q;
  logic [NUM_GRP-1:0][7:0]   ctl_byte;
  logic [NUM_GRP-1:0]        wr_grp;
  logic [TW-1:0]             rd_next;

  ecq_sync_edge #(.NUM_CH(NUM_CH)) u_sync (
    .clk(clk), .rst(rst), .pin(pin_i), .sel(sel_q), .hit(edge_hit)
  );

  ecq_capture_bank #(.NUM_CH(NUM_CH), .TW(TW)) u_cap (
    .clk(clk), .rst(rst), .hit(edge_hit), .cnt(cnt_i), .cap(cap_q)
  );

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_dec
    assign wr_grp[g] = bus_wr && (bus_addr == AW'(NUM_CH + g));
  end

  ecq_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk(clk), .rst(rst), .wr_grp(wr_grp), .wdata(bus_wdata), .hit(edge_hit),
    .flag(flag_q), .ien(ien_q), .sel(sel_q), .ctl_byte(ctl_byte)
  );

  always_comb begin
    rd_next = '0;
    for (int c = 0; c < NUM_CH; c++)
      if (bus_addr == AW'(c)) rd_next = cap_q[c];
    for (int g = 0; g < NUM_GRP; g++)
      if (bus_addr == AW'(NUM_CH + g))
        rd_next = {{(TW-8){1'b0}}, ctl_byte[g] | (bus_rmw ? 8'hC0 : 8'h00)};
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_next;
  end

  assign irq_o = flag_q & ien_q;
endmodule

// File: rtl/ecq_checker.sv
module ecq_checker #(
  parameter int  NUM_CH = 4,
  parameter int  TW     = 16,
  localparam int AW     = $clog2(NUM_CH + NUM_CH / 2)
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      bus_wr,
  input logic                      bus_rd,
  input logic [AW-1:0]             bus_addr,
  input logic [7:0]                bus_wdata,
  input logic [TW-1:0]             bus_rdata,
  input logic [TW-1:0]             cnt_i,
  input logic [NUM_CH-1:0]         hit,
  input logic [NUM_CH-1:0]         flag,
  input logic [NUM_CH-1:0][TW-1:0] cap
);
  a_r11_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam int CTL = NUM_CH + i / 2;
    localparam int FB  = 6 + (i % 2);

    a_r1_capture_value: assert property (@(posedge clk) disable iff (rst)
      hit[i] |=> cap[i] == $past(cnt_i));
    a_r3_capture_hold: assert property (@(posedge clk) disable iff (rst)
      !hit[i] |=> $stable(cap[i]));
    a_r5_flag_on_edge: assert property (@(posedge clk) disable iff (rst)
      hit[i] |=> flag[i]);
    a_r6_one_keeps: assert property (@(posedge clk) disable iff (rst)
      (flag[i] && bus_wr && bus_addr == AW'(CTL) && bus_wdata[FB]) |=> flag[i]);
    a_r6_zero_clears: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && bus_addr == AW'(CTL) && !bus_wdata[FB] && !hit[i]) |=> !flag[i]);
  end
endmodule

bind edge_capture_quad ecq_checker #(.NUM_CH(NUM_CH), .TW(TW)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_i(cnt_i),
  .hit(edge_hit), .flag(flag_q), .cap(cap_q)
);

// File: tb/edge_capture_quad_tb.sv
`timescale 1ns/1ps
module edge_capture_quad_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cnt = 16'h1230;
  logic [3:0]  pin = '0;
  logic [2:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0, rmw = 1'b0;
  logic [7:0]  wdata = '0;
  logic [15:0] rdata;
  logic [3:0]  irq;

  int n_chk = 0, n_fail = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cnt <= cnt + 16'd1;

  edge_capture_quad u_dut (
    .clk(clk), .rst(rst), .cnt_i(cnt), .pin_i(pin), .bus_addr(addr),
    .bus_wr(wr), .bus_rd(rd), .bus_rmw(rmw), .bus_wdata(wdata),
    .bus_rdata(rdata), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr <= 1'b1; addr <= a; wdata <= d;
    @(negedge clk);
    wr <= 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, input logic m, input logic [15:0] exp, input string tag);
    @(negedge clk);
    rd <= 1'b1; addr <= a; rmw <= m;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    rd <= 1'b0; rmw <= 1'b0;
  endtask

  task automatic set_pin(input int ch, input logic v, output logic [15:0] exp_cap);
    @(negedge clk);
    pin[ch] <= v;
    exp_cap = cnt + 16'd2;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // monitor: rd still holds its old value at this negedge
  always @(negedge clk) begin
    if (rd && !rst) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R11 actual=%h expected=<no pending read>", rdata);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, rdata, e);
      end
    end
  end

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] c0, c1, c2, c2b, c0b;
    repeat (3) @(posedge clk);
    @(negedge clk); rst <= 1'b0;
    @(negedge clk);
    check("R10 rdata after reset", rdata, 16'h0);
    check("R10 irq after reset", {12'h0, irq}, 16'h0);
    bus_read(3'd4, 1'b0, 16'h0000, "R10 ctl0 reset");
    bus_read(3'd5, 1'b0, 16'h0000, "R10 ctl1 reset");
    bus_read(3'd0, 1'b0, 16'h0000, "R10 cap0 reset");

    // ch0 rise+en, ch1 fall no en; ch2 both+en, ch3 off+en
    bus_write(3'd4, 8'h19);
    bus_write(3'd5, 8'h33);
    bus_read(3'd4, 1'b0, 16'h0019, "R4 ctl0 layout");
    bus_read(3'd5, 1'b0, 16'h0033, "R4 ctl1 layout");

    set_pin(0, 1'b1, c0); idle(5);
    check("R9 irq0 after rise", {15'h0, irq[0]}, 16'h1);
    bus_read(3'd0, 1'b0, c0, "R1 cap0 rising");
    bus_read(3'd4, 1'b0, 16'h0059, "R5 flag0 set");

    set_pin(0, 1'b0, c0b); idle(5);
    bus_read(3'd0, 1'b0, c0, "R2 falling ignored on rise channel");

    set_pin(1, 1'b1, c1); idle(5);
    bus_read(3'd1, 1'b0, 16'h0000, "R2 rising ignored on fall channel");
    bus_read(3'd4, 1'b0, 16'h0059, "R2 no flag1 on rising");
    set_pin(1, 1'b0, c1); idle(5);
    bus_read(3'd1, 1'b0, c1, "R1 cap1 falling");
    bus_read(3'd4, 1'b0, 16'h00D9, "R5 flag1 set");
    check("R9 irq1 off without enable", {15'h0, irq[1]}, 16'h0);

    set_pin(2, 1'b1, c2); idle(5);
    bus_read(3'd2, 1'b0, c2, "R2 both: rising capture");
    set_pin(2, 1'b0, c2b); idle(5);
    bus_read(3'd2, 1'b0, c2b, "R2 both: falling capture");
    check("R9 irq2", {15'h0, irq[2]}, 16'h1);

    set_pin(3, 1'b1, c0b); idle(3);
    set_pin(3, 1'b0, c0b); idle(5);
    bus_read(3'd3, 1'b0, 16'h0000, "R2 selector off no capture");
    bus_read(3'd5, 1'b0, 16'h0073, "R2 selector off no flag");
    check("R9 irq3 low with no flag", {15'h0, irq[3]}, 16'h0);

    bus_write(3'd0, 8'hFF);
    bus_read(3'd0, 1'b0, c0, "R3 write to cap0 ignored");

    bus_write(3'd4, 8'h59);
    bus_read(3'd4, 1'b0, 16'h0059, "R6 clear flag1 keep flag0");
    check("R6 irq0 kept", {15'h0, irq[0]}, 16'h1);
    bus_read(3'd4, 1'b1, 16'h00D9, "R8 rmw view of flags");
    bus_read(3'd4, 1'b0, 16'h0059, "R8 rmw read leaves flags");

    bus_write(3'd4, 8'h19);
    bus_read(3'd4, 1'b0, 16'h0019, "R6 clear flag0");
    check("R9 irq0 drops on clear", {15'h0, irq[0]}, 16'h0);
    bus_write(3'd4, 8'hD9);
    bus_read(3'd4, 1'b0, 16'h0019, "R6 writing 1 does not set");

    // set/clear collision: write lands on the capture edge
    set_pin(0, 1'b1, c0);
    @(negedge clk);
    @(negedge clk); wr <= 1'b1; addr <= 3'd4; wdata <= 8'h19;
    @(negedge clk); wr <= 1'b0;
    idle(2);
    bus_read(3'd4, 1'b0, 16'h0059, "R7 set wins over clear");
    bus_read(3'd0, 1'b0, c0, "R1 cap0 during collision");

    bus_write(3'd4, 8'h49);
    check("R9 irq0 low when disabled", {15'h0, irq[0]}, 16'h0);
    bus_read(3'd4, 1'b0, 16'h0049, "R9 flag held while disabled");

    @(negedge clk); addr <= 3'd1;
    idle(2);
    check("R11 rdata holds without read", rdata, 16'h0049);

    idle(3);
    if (exp_q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL R11 actual=%0d expected=0 unanswered reads", exp_q.size());
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule